// File: doc/BRIEF.md
# Ethernet receive frame judge with interrupt status

This block sits beside an Ethernet receive path and decides, for every frame, whether the frame is kept or thrown away. It counts the bytes of the frame as they arrive, remembers any receive-FIFO overflow seen during the frame, and at the end-of-frame pulse combines the length, the CRC-check result and the overflow into a verdict. Two software controls relax the rules. One lets over-length frames through as good frames. The other does the same for frames that fail the CRC check.

Each verdict also sets sticky status bits. Software reads them and clears them by writing 1 through a small synchronous register port. A second register holds one enable per status bit. The single receive interrupt is high while any enabled status bit is set.

Top module: `eth_rx_judge`

## Requirements
- R1: After reset the status register and the enable register read 0 and `rx_irq` is low.
- R2: The frame length is the number of cycles with `byte_vld` high since the previous end of frame, including the `frame_end` cycle itself. A frame longer than 1518 bytes is dropped and sets status bit 3, unless `accept_long` is high. With `accept_long` high it is kept and bit 3 stays clear. A frame of exactly 1518 bytes is not long.
- R3: A frame with `crc_bad` high in its `frame_end` cycle is dropped and sets status bit 1, unless `accept_err` is high. With `accept_err` high it is kept and bit 1 stays clear.
- R4: A `fifo_ovf` pulse in any cycle of a frame, including its `frame_end` cycle, drops that frame and sets status bit 2. An overflow does not carry over into the next frame.
- R5: A kept frame sets status bit 4. A dropped frame does not set bit 4. A frame with several faults sets all of their status bits together.
- R6: Writing the status register (address 0) clears each bit written as 1. Bits written as 0 are unchanged. A bit set by a frame in the same cycle as it is cleared ends up set.
- R7: The enable register is at address 1 and uses the same bit positions as the status register. `rx_irq` is high exactly when some status bit and its enable bit are both 1.
- R8: Status bits 7, 6, 5 and 0, and the same bits of the enable register, always read 0.
- R9: `frame_keep` or `frame_drop` (never both) is high in the `frame_end` cycle and in no other cycle. Status bits change on the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One received frame byte this cycle |
| frame_end | input | 1 | Last cycle of the frame |
| crc_bad | input | 1 | CRC check failed, valid with frame_end |
| fifo_ovf | input | 1 | Receive FIFO overflow this cycle |
| accept_long | input | 1 | Treat over-length frames as good |
| accept_err | input | 1 | Treat CRC-failed frames as good |
| frame_keep | output | 1 | Frame kept, pulse with frame_end |
| frame_drop | output | 1 | Frame dropped, pulse with frame_end |
| reg_addr | input | 1 | 0 status, 1 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| rx_irq | output | 1 | Masked receive interrupt |

## Verification
A frame verdict that sets status bits and a software write that clears them can fall in the same cycle. The bench provokes this by holding a write of 1s to the status register during the `frame_end` cycle of chosen frames, both for bits that the frame sets and for bits it does not set. It then reads the register back and expects set bits to win, while the other written bits are cleared. Random frames near the 1518-byte boundary, with random faults and controls, are judged against a bench model of the verdict and of the status register.

// File: rtl/eth_rx_judge_pkg.sv
package eth_rx_judge_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_CRC    = 1;
    localparam int BIT_OVF    = 2;
    localparam int BIT_LONG   = 3;
    localparam int BIT_GOOD   = 4;
    localparam logic [REG_W-1:0] STAT_MASK =
        REG_W'((1 << BIT_CRC) | (1 << BIT_OVF) | (1 << BIT_LONG) | (1 << BIT_GOOD));

    typedef struct packed {
        logic good;
        logic too_long;
        logic ovf;
        logic crc;
    } verdict_t;
endpackage

// File: rtl/eth_rx_frame_judge.sv
module eth_rx_frame_judge
    import eth_rx_judge_pkg::*;
#(
    parameter int MAX_LEN = 1518
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     byte_vld,
    input  logic     frame_end,
    input  logic     crc_bad,
    input  logic     fifo_ovf,
    input  logic     accept_long,
    input  logic     accept_err,
    output logic     frame_keep,
    output logic     frame_drop,
    output verdict_t set_bits
);
    localparam int CNT_W = $clog2(MAX_LEN + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } judge_st_t;

    judge_st_t st_d, st_q;
    logic [CNT_W-1:0] len_now;
    logic ovf_now, is_long, bad_long, bad_crc, drop;

    always_comb begin
        len_now = st_q.cnt;
        if (byte_vld && st_q.cnt != SAT) len_now = st_q.cnt + 1'b1;
        ovf_now  = st_q.ovf | fifo_ovf;
        is_long  = len_now > CNT_W'(MAX_LEN);
        bad_long = is_long & ~accept_long;
        bad_crc  = crc_bad & ~accept_err;
        drop     = bad_long | bad_crc | ovf_now;

        frame_keep = frame_end & ~drop;
        frame_drop = frame_end & drop;

        set_bits.good     = frame_end & ~drop;
        set_bits.too_long = frame_end & bad_long;
        set_bits.ovf      = frame_end & ovf_now;
        set_bits.crc      = frame_end & bad_crc;

        st_d = st_q;
        if (frame_end) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else begin
            st_d.cnt = len_now;
            st_d.ovf = ovf_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_keep && frame_drop));
    p_verdict_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> !(frame_keep || frame_drop));
    p_crc_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && crc_bad && !accept_err) |-> frame_drop);
    p_ovf_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && fifo_ovf) |-> (frame_drop && set_bits.ovf));
    p_ovf_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !st_q.ovf);
endmodule

// File: rtl/eth_rx_irq_regs.sv
module eth_rx_irq_regs
    import eth_rx_judge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  verdict_t         set_bits,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             rx_irq
);
    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] enable;
    } regs_t;

    regs_t r_d, r_q;
    logic [REG_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_GOOD] = set_bits.good;
        set_vec[BIT_LONG] = set_bits.too_long;
        set_vec[BIT_OVF]  = set_bits.ovf;
        set_vec[BIT_CRC]  = set_bits.crc;
        clr_vec = (reg_wr && !reg_addr) ? reg_wdata : '0;

        r_d = r_q;
        r_d.status = ((r_q.status & ~clr_vec) | set_vec) & STAT_MASK;
        if (reg_wr && reg_addr) r_d.enable = reg_wdata & STAT_MASK;

        reg_rdata = reg_addr ? r_q.enable : r_q.status;
        rx_irq    = |(r_q.status & r_q.enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((r_q.status & $past(set_vec)) == $past(set_vec)));
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_addr) |=> ((r_q.status & $past(r_q.status)) == $past(r_q.status)));
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.status | r_q.enable) & ~STAT_MASK) == '0);
    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.enable == '0) |-> !rx_irq);
endmodule

// File: rtl/eth_rx_judge.sv
module eth_rx_judge
    import eth_rx_judge_pkg::*;
#(
    parameter int MAX_LEN = 1518
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       frame_end,
    input  logic       crc_bad,
    input  logic       fifo_ovf,
    input  logic       accept_long,
    input  logic       accept_err,
    output logic       frame_keep,
    output logic       frame_drop,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rx_irq
);
    verdict_t set_bits;

    eth_rx_frame_judge #(.MAX_LEN(MAX_LEN)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .frame_end   (frame_end),
        .crc_bad     (crc_bad),
        .fifo_ovf    (fifo_ovf),
        .accept_long (accept_long),
        .accept_err  (accept_err),
        .frame_keep  (frame_keep),
        .frame_drop  (frame_drop),
        .set_bits    (set_bits)
    );

    eth_rx_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_bits  (set_bits),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_irq    (rx_irq)
    );
endmodule

// File: tb/test_eth_rx_judge.sv
module test_eth_rx_judge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_vld = 0, frame_end = 0, crc_bad = 0, fifo_ovf = 0;
    logic accept_long = 0, accept_err = 0;
    logic frame_keep, frame_drop;
    logic reg_addr = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic rx_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_stat = 0;
    logic [7:0] exp_en = 0;

    always #10 clk = ~clk;

    eth_rx_judge i_eth_rx_judge (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_set(input int len, input bit crc, input bit ovf,
                                             input bit al, input bit ae);
        logic [7:0] s = 0;
        bit lg = (len > 1518) && !al;
        bit cb = crc && !ae;
        s[3] = lg; s[1] = cb; s[2] = ovf;
        s[4] = !(lg || cb || ovf);
        return s;
    endfunction

    // send a frame; ovf_idx < 0 means no overflow; clr is written to status in the end cycle
    task automatic send(input string req, input int len, input bit crc, input int ovf_idx,
                        input bit al, input bit ae, input logic [7:0] clr);
        logic [7:0] s;
        s = frame_set(len, crc, ovf_idx >= 0, al, ae);
        accept_long = al; accept_err = ae;
        for (int i = 0; i < len; i++) begin
            byte_vld = 1;
            fifo_ovf = (i == ovf_idx);
            if (i == len - 1) begin
                frame_end = 1; crc_bad = crc;
                if (clr != 0) begin reg_wr = 1; reg_addr = 0; reg_wdata = clr; end
                #1;
                chk({req, " keep"}, frame_keep, s[4]);
                chk({req, " drop"}, frame_drop, !s[4]);
            end else if (i == 0 || i == len - 2) begin
                #1;
                chk("R9 no verdict mid-frame", {frame_keep, frame_drop}, 0);
            end
            @(negedge clk);
        end
        exp_stat = (exp_stat & ~clr) | s;
        byte_vld = 0; frame_end = 0; crc_bad = 0; fifo_ovf = 0; reg_wr = 0;
        reg_addr = 0; #1;
        chk({req, " status"}, reg_rdata, exp_stat);
        chk("R7 irq", rx_irq, |(exp_stat & exp_en));
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        if (a) exp_en = d & 8'h1E; else exp_stat = exp_stat & ~d;
    endtask

    task automatic rd(input string req, input bit a);
        reg_addr = a; #1;
        chk(req, reg_rdata, a ? exp_en : exp_stat);
        chk("R7 irq", rx_irq, |(exp_stat & exp_en));
    endtask

    initial begin
        int unsigned seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd("R1 reset status", 0);
        rd("R1 reset enable", 1);
        chk("R1 irq low", rx_irq, 0);

        // directed length boundary (R2)
        send("R2 len 1518", 1518, 0, -1, 0, 0, 0);
        send("R2 len 1519", 1519, 0, -1, 0, 0, 0);
        send("R2 len 1519 accepted", 1519, 0, -1, 1, 0, 8'h1E);
        // CRC (R3)
        send("R3 crc bad", 64, 1, -1, 0, 0, 8'h1E);
        send("R3 crc accepted", 64, 1, -1, 0, 1, 8'h1E);
        // overflow first and last byte, no carry over (R4)
        send("R4 ovf first", 70, 0, 0, 0, 0, 8'h1E);
        send("R4 ovf at end", 70, 0, 69, 0, 0, 8'h1E);
        send("R4 next frame clean", 70, 0, -1, 0, 0, 8'h1E);
        // all faults at once (R5)
        send("R5 multi fault", 1600, 1, 10, 0, 0, 8'h1E);
        // set wins over clear in the same cycle (R6)
        send("R6 set wins", 1530, 1, -1, 0, 0, 8'h1E);
        // write 0 keeps, write 1 clears (R6)
        wr(0, 8'h00); rd("R6 write zero no effect", 0);
        wr(0, 8'h08); rd("R6 clear one bit", 0);
        // enable register and irq (R7, R8)
        wr(1, 8'hFF); rd("R8 enable unused zero", 1);
        rd("R7 irq with enable", 0);
        wr(0, 8'hFF); rd("R8 status cleared", 0);
        chk("R7 irq low no status", rx_irq, 0);
        wr(1, 8'h10);
        send("R7 good frame irq", 60, 0, -1, 0, 0, 0);
        wr(0, 8'hE1); rd("R8 unused write no effect", 0);
        wr(1, 8'h08);
        send("R7 irq masked", 60, 0, -1, 0, 0, 8'h1E);

        // random frames
        for (int n = 0; n < 40; n++) begin
            int len;
            int ov;
            case ($urandom % 3)
                0: len = 1 + $urandom % 100;
                1: len = 1510 + $urandom % 20;
                default: len = 100 + $urandom % 1500;
            endcase
            ov = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
            if ($urandom % 3 == 0) wr(1, 8'($urandom));
            send("R2 R3 R4 R5 random", len, 1'($urandom), ov, 1'($urandom), 1'($urandom),
                 ($urandom % 2) ? 8'($urandom) : 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule